// File: doc/BRIEF.md
# Serial Transmitter Channel with Clear-to-Send Gating and Self-Releasing Request-to-Send

This block is one asynchronous serial transmit channel. It sends 5 to 8 data bits, least significant bit first, behind a low start bit. An optional even or odd parity bit follows the data, then a stop interval whose length is set in sixteenths of a bit. Timing comes from a baud clock enable that pulses 16 times per bit. A 1x mode is also provided, in which each enable pulse is one whole bit. Software writes characters into a one-deep holding register and watches a ready flag and an empty flag.

When clear-to-send gating is on, a character starts only while the active-low clear-to-send input is low. The block also owns an active-low request-to-send output, which is driven by separate set and clear pulses. In auto-release mode a pending disable lets the last characters drain. One bit time after the final stop interval, request-to-send is then released and the channel turns itself off. Baud-rate generation, reception and bus decoding are outside the block.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `txd_o`=1, `rdy_o`=0, `emt_o`=0 and `rts_no`=1.
- R2: While the channel is disabled, writes are ignored and both flags stay 0. One cycle after a `tx_en_i` pulse, `rdy_o`=1 and `emt_o`=1 (the underrun state).
- R3: A frame is made of a 0 start bit, then 5+`char_len_i` data bits sent LSB first, then a parity bit if `par_en_i`=1, then the stop interval at 1. Each bit lasts 16 baud enables. Parity makes the count of ones even when `par_odd_i`=0 and odd when it is 1. The line sits at 1 when no frame is being sent.
- R4: For 6, 7 and 8-bit characters (`char_len_i` 1 to 3), a stop field value n gives 9+n sixteenths when n<8 and 17+n sixteenths when n>=8.
- R5: For 5-bit characters (`char_len_i`=0), n<8 gives 17+n sixteenths. n>=8 gives 17+n.
- R6: When `x1_mode_i`=1, each bit lasts one baud enable. The stop interval is 1 enable if `stop_sel_i[3]`=0 and 2 enables if it is 1.
- R7: With `cts_gate_i`=1, a character that is due to start while `cts_ni`=1 is held back. The line stays at 1 and the holding register stays full until `cts_ni` goes low. With `cts_gate_i`=0, `cts_ni` is ignored.
- R8: A change on `cts_ni` after a frame has started does not change that frame.
- R9: An accepted write clears `rdy_o`. A write while `rdy_o`=0 is ignored. `rdy_o` sets when the character moves into the shifter. `emt_o`=1 only when the holding register is empty and no frame is in progress.
- R10: `rts_set_i` drives `rts_no` low and `rts_clr_i` drives it high, one cycle later. When both pulse together, the clear wins.
- R11: With `rts_auto_i`=1 and a disable pending, the block sends every queued character, including the full stop interval. After that it holds the line at mark for one bit time (16 enables, or 1 in 1x mode), then sets `rts_no`=1 and disables the channel, so `rdy_o`=`emt_o`=0. During that bit time `rdy_o`=0 and `emt_o`=1.
- R12: Without auto-release, a pending disable takes effect at the first point where no frame is running and the holding register is empty. `rts_no` is left unchanged.
- R13: A `tx_en_i` pulse cancels a pending disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Baud enable: 16 per bit, or 1 per bit in 1x mode |
| x1_mode_i | input | 1 | 1x timing mode |
| char_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| stop_sel_i | input | 4 | Stop interval select |
| cts_gate_i | input | 1 | Gate character starts on clear-to-send |
| rts_auto_i | input | 1 | Release request-to-send automatically after a drained disable |
| cts_ni | input | 1 | Clear-to-send, active low |
| tx_en_i | input | 1 | Enable pulse |
| tx_dis_i | input | 1 | Disable pulse |
| rts_set_i | input | 1 | Assert request-to-send |
| rts_clr_i | input | 1 | Release request-to-send |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | 8 | Character to send |
| rdy_o | output | 1 | Holding register can take a character |
| emt_o | output | 1 | Holding register and shifter both empty |
| txd_o | output | 1 | Serial output |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
The bench measures the time between two back-to-back character loads across the stop table. This covers both ends of each range and the raised 5-bit low half. A wrong table entry or an off-by-one stop count would stretch or shrink the measured frame. Clear-to-send is held high across a start opportunity and then toggled in mid-frame. A design that sampled it too late, or at every bit, would send early or cut the frame. The auto-release sequence is timed from the start of the trailing mark bit to the release of request-to-send, and disables are issued in idle and during a frame and then cancelled. This catches a release that comes too early, a channel that shuts down with data still queued, and a cancelled disable that still takes effect.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVS      = 16;
  localparam int DATA_W   = 8;
  localparam int MIN_BITS = 5;
  localparam int LEN_W    = 2;
  localparam int SEL_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_TAIL
  } tx_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_en;
    logic             par_odd;
    logic             x1;
  } tx_cfg_t;
endpackage

// File: rtl/uart_tx_stop_len.sv
module uart_tx_stop_len
  import uart_tx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             x1_i,
  output logic [CNT_W-1:0] ticks_o
);
  localparam int HALF = 1 << (SEL_W - 1);
  int t;

  // sixteenths: low half offset 9 (17 for 5-bit chars), high half offset 17
  always_comb begin
    if (x1_i)
      t = sel_i[SEL_W-1] ? 2 : 1;
    else if (int'(sel_i) >= HALF || len_i == '0)
      t = 17 + int'(sel_i);
    else
      t = 9 + int'(sel_i);
    ticks_o = CNT_W'(t);
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tail_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o
);
  logic accept;

  assign rdy_o  = en_i & ~full_o & ~tail_i;
  assign accept = wr_i & rdy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      if (take_i)      full_o <= 1'b0;
      else if (accept) full_o <= 1'b1;
      if (accept)      data_o <= data_i;
    end
  end
endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_cmd_i,
  input  logic dis_cmd_i,
  input  logic rts_set_i,
  input  logic rts_clr_i,
  input  logic halt_i,
  input  logic drop_i,
  output logic en_o,
  output logic pend_o,
  output logic rts_no
);
  logic rts_q;

  assign rts_no = ~rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      pend_o <= 1'b0;
      rts_q  <= 1'b0;
    end else begin
      if (en_cmd_i) begin
        en_o   <= 1'b1;
        pend_o <= 1'b0;
      end else if (halt_i) begin
        en_o   <= 1'b0;
        pend_o <= 1'b0;
      end else if (dis_cmd_i && en_o) begin
        pend_o <= 1'b1;
      end
      // any release wins over a set
      if (rts_clr_i || drop_i) rts_q <= 1'b0;
      else if (rts_set_i)      rts_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              pend_i,
  input  logic              auto_i,
  input  logic              cts_ok_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] data_i,
  input  tx_cfg_t           cfg_i,
  input  logic [CNT_W-1:0]  stop_ticks_i,
  output logic              take_o,
  output logic              halt_o,
  output logic              drop_o,
  output logic              busy_o,
  output logic              tail_o,
  output logic              idle_o,
  output logic              txd_o
);
  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, stop_q, bit_last;
  logic [IDX_W-1:0]  idx_q, last_idx_q;
  logic [DATA_W-1:0] sh_q, mask, masked;
  logic              par_q, pe_q, x1_q;
  logic              can_load, bit_end, stop_end, seg_end;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      mask[i] = (i < MIN_BITS + int'(cfg_i.len));
    masked = data_i & mask;
  end

  assign bit_last = x1_q ? '0 : CNT_W'(OVS - 1);
  assign bit_end  = tick_i && (cnt_q == bit_last);
  assign stop_end = tick_i && (cnt_q == stop_q - 1'b1);
  assign seg_end  = (state_q == ST_STOP) ? stop_end : bit_end;
  assign can_load = tick_i & en_i & full_i & cts_ok_i;

  always_comb begin
    state_d = state_q;
    take_o  = 1'b0;
    halt_o  = 1'b0;
    drop_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (can_load)                   take_o = 1'b1;
        else if (en_i && pend_i && !full_i) halt_o = 1'b1;
      end
      ST_START: if (bit_end) state_d = ST_DATA;
      ST_DATA: begin
        if (bit_end && idx_q == last_idx_q) state_d = pe_q ? ST_PAR : ST_STOP;
      end
      ST_PAR: if (bit_end) state_d = ST_STOP;
      ST_STOP: begin
        if (stop_end) begin
          if (can_load) take_o = 1'b1;
          else begin
            state_d = ST_IDLE;
            if (pend_i && !full_i) begin
              if (auto_i) state_d = ST_TAIL;
              else        halt_o  = 1'b1;
            end
          end
        end
      end
      ST_TAIL: begin
        if (bit_end) begin
          state_d = ST_IDLE;
          if (pend_i) begin
            halt_o = 1'b1;
            drop_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (take_o) state_d = ST_START;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      last_idx_q <= '0;
      sh_q       <= '0;
      par_q      <= 1'b0;
      pe_q       <= 1'b0;
      x1_q       <= 1'b0;
      stop_q     <= CNT_W'(1);
    end else begin
      state_q <= state_d;
      if (take_o)
        cnt_q <= '0;
      else if (tick_i && state_q != ST_IDLE)
        cnt_q <= seg_end ? '0 : cnt_q + 1'b1;
      if (take_o) begin
        // frame settings are frozen per character
        sh_q       <= masked;
        par_q      <= (^masked) ^ cfg_i.par_odd;
        pe_q       <= cfg_i.par_en;
        x1_q       <= cfg_i.x1;
        stop_q     <= stop_ticks_i;
        last_idx_q <= IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_i.len);
        idx_q      <= '0;
      end else if (state_q == ST_DATA && bit_end && idx_q != last_idx_q) begin
        idx_q <= idx_q + 1'b1;
        sh_q  <= sh_q >> 1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q == ST_START) || (state_q == ST_DATA) ||
                  (state_q == ST_PAR)   || (state_q == ST_STOP);
  assign tail_o = (state_q == ST_TAIL);
  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              x1_mode_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [SEL_W-1:0]  stop_sel_i,
  input  logic              cts_gate_i,
  input  logic              rts_auto_i,
  input  logic              cts_ni,
  input  logic              tx_en_i,
  input  logic              tx_dis_i,
  input  logic              rts_set_i,
  input  logic              rts_clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic              emt_o,
  output logic              txd_o,
  output logic              rts_no
);
  localparam int CNT_W = $clog2(2 * OVS + 1);

  tx_cfg_t           cfg;
  logic [CNT_W-1:0]  stop_ticks;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full, en, pend, cts_ok;
  logic              frm_take, frm_halt, frm_drop, frm_busy, frm_tail, frm_idle;

  assign cfg.len     = char_len_i;
  assign cfg.par_en  = par_en_i;
  assign cfg.par_odd = par_odd_i;
  assign cfg.x1      = x1_mode_i;
  assign cts_ok      = ~cts_gate_i | ~cts_ni;

  uart_tx_stop_len #(.CNT_W(CNT_W)) u_stop (
    .len_i   (char_len_i),
    .sel_i   (stop_sel_i),
    .x1_i    (x1_mode_i),
    .ticks_o (stop_ticks)
  );

  uart_tx_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tail_i (frm_tail),
    .wr_i   (wr_i),
    .data_i (wdata_i),
    .take_i (frm_take),
    .full_o (hold_full),
    .data_o (hold_data),
    .rdy_o  (rdy_o)
  );

  uart_tx_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_cmd_i  (tx_en_i),
    .dis_cmd_i (tx_dis_i),
    .rts_set_i (rts_set_i),
    .rts_clr_i (rts_clr_i),
    .halt_i    (frm_halt),
    .drop_i    (frm_drop),
    .en_o      (en),
    .pend_o    (pend),
    .rts_no    (rts_no)
  );

  uart_tx_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (baud_tick_i),
    .en_i         (en),
    .pend_i       (pend),
    .auto_i       (rts_auto_i),
    .cts_ok_i     (cts_ok),
    .full_i       (hold_full),
    .data_i       (hold_data),
    .cfg_i        (cfg),
    .stop_ticks_i (stop_ticks),
    .take_o       (frm_take),
    .halt_o       (frm_halt),
    .drop_o       (frm_drop),
    .busy_o       (frm_busy),
    .tail_o       (frm_tail),
    .idle_o       (frm_idle),
    .txd_o        (txd_o)
  );

  assign emt_o = en & ~hold_full & (frm_idle | frm_tail);
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic cts_gate_i,
  input logic cts_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic rts_set_i,
  input logic rts_clr_i,
  input logic rdy_o,
  input logic emt_o,
  input logic txd_o,
  input logic rts_no,
  input logic frm_idle,
  input logic frm_busy,
  input logic frm_drop
);
  AST_WR_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && wr_i) |=> !rdy_o); // R9

  AST_CTS_HOLDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_idle && cts_gate_i && cts_ni) |=> !frm_busy); // R7

  AST_RTS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_clr_i |=> rts_no); // R10

  AST_RTS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_set_i && !rts_clr_i && !frm_drop) |=> !rts_no); // R10

  AST_LINE_MARK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emt_o |-> txd_o); // R3

  AST_TXD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !baud_tick_i |=> $stable(txd_o)); // R3

  AST_AUTO_DROP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rts_no) && !$past(rts_clr_i) && !$past(tx_en_i)) |-> (!rdy_o && !emt_o)); // R11
endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_tick_i (baud_tick_i),
  .cts_gate_i  (cts_gate_i),
  .cts_ni      (cts_ni),
  .tx_en_i     (tx_en_i),
  .wr_i        (wr_i),
  .rts_set_i   (rts_set_i),
  .rts_clr_i   (rts_clr_i),
  .rdy_o       (rdy_o),
  .emt_o       (emt_o),
  .txd_o       (txd_o),
  .rts_no      (rts_no),
  .frm_idle    (frm_idle),
  .frm_busy    (frm_busy),
  .frm_drop    (frm_drop)
);

// File: tb/sim_uart_tx_flow.sv
`timescale 1ns/1ps
module sim_uart_tx_flow;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       x1_mode_i = 1'b0;
  logic [1:0] char_len_i = 2'd3;
  logic       par_en_i = 1'b0, par_odd_i = 1'b0;
  logic [3:0] stop_sel_i = 4'd7;
  logic       cts_gate_i = 1'b0, rts_auto_i = 1'b0, cts_ni = 1'b0;
  logic       tx_en_i = 1'b0, tx_dis_i = 1'b0, rts_set_i = 1'b0, rts_clr_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       rdy_o, emt_o, txd_o, rts_no;

  int n_cmp = 0, n_err = 0, cyc = 0, tick_div = 1, tick_ctr = 0;

  uart_tx_flow u0 (.*, .clk_i(clk));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_ctr >= tick_div - 1) tick_ctr = 0; else tick_ctr++;
    baud_tick_i = (tick_ctr == 0);
  end

  // ---------------- reference model ----------------
  bit m_en, m_pend, m_rts, m_full, m_busy, m_x1, m_txd;
  bit [7:0] m_data;
  int m_tail;
  bit q[$];

  function automatic int stop_sixteenths(int len, int sel, bit x1);
    if (x1) return (sel >= 8) ? 2 : 1;
    if (sel >= 8 || len == 0) return 17 + sel;
    return 9 + sel;
  endfunction

  function void model_load();
    int nb, seg, ones;
    bit p;
    nb = 5 + int'(char_len_i);
    seg = x1_mode_i ? 1 : 16;
    q.delete();
    ones = 0;
    for (int k = 0; k < seg; k++) q.push_back(1'b0);
    for (int b = 0; b < nb; b++) begin
      ones += int'(m_data[b]);
      for (int k = 0; k < seg; k++) q.push_back(m_data[b]);
    end
    p = bit'(ones % 2) ^ par_odd_i;
    if (par_en_i) for (int k = 0; k < seg; k++) q.push_back(p);
    for (int k = 0; k < stop_sixteenths(int'(char_len_i), int'(stop_sel_i), x1_mode_i); k++)
      q.push_back(1'b1);
    m_x1 = x1_mode_i;
    m_txd = q.pop_front();
    m_busy = 1'b1;
    m_full = 1'b0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    bit idle_pre, rdy_pre, en_pre, ended, halt, drop, can;
    if (!rst_ni) begin
      m_en = 0; m_pend = 0; m_rts = 0; m_full = 0; m_busy = 0; m_x1 = 0;
      m_txd = 1; m_data = 0; m_tail = 0; q.delete();
    end else begin
      idle_pre = !m_busy && (m_tail == 0);
      rdy_pre  = m_en && !m_full && (m_tail == 0);
      en_pre   = m_en;
      ended = 0; halt = 0; drop = 0;
      can = baud_tick_i && m_en && m_full && (!cts_gate_i || !cts_ni);
      if (baud_tick_i && m_busy) begin
        if (q.size() > 0) m_txd = q.pop_front(); else ended = 1;
      end else if (baud_tick_i && m_tail > 0) begin
        m_tail--;
        if (m_tail == 0 && m_pend) begin halt = 1; drop = 1; end
      end
      if (ended) begin
        m_busy = 0; m_txd = 1;
        if (can) model_load();
        else if (m_pend && !m_full) begin
          if (rts_auto_i) m_tail = m_x1 ? 1 : 16; else halt = 1;
        end
      end else if (idle_pre) begin
        if (can) model_load();
        else if (m_en && m_pend && !m_full) halt = 1;
      end
      if (wr_i && rdy_pre) begin m_full = 1; m_data = wdata_i; end
      if (tx_en_i) begin m_en = 1; m_pend = 0; end
      else if (halt) begin m_en = 0; m_pend = 0; end
      else if (tx_dis_i && en_pre) m_pend = 1;
      if (rts_clr_i || drop) m_rts = 0; else if (rts_set_i) m_rts = 1;
    end
  end

  wire m_rdy = m_en && !m_full && (m_tail == 0);
  wire m_emt = m_en && !m_full && !m_busy;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  always @(negedge clk) if (rst_ni) begin
    n_cmp++;
    if (txd_o !== m_txd || rdy_o !== m_rdy || emt_o !== m_emt || rts_no !== !m_rts) begin
      n_err++;
      $display("FAIL R3/R9/R10 cyc %0d: txd %b/%b rdy %b/%b emt %b/%b rts_n %b/%b (act/exp)",
               cyc, txd_o, m_txd, rdy_o, m_rdy, emt_o, m_emt, rts_no, !m_rts);
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rdy();
    int g = 0;
    while (!rdy_o && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_emt();
    int g = 0;
    while (!emt_o && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic send(logic [7:0] d);
    wait_rdy();
    wr_i = 1; wdata_i = d;
    @(negedge clk);
    wr_i = 0;
  endtask

  task automatic pulse_en();  tx_en_i = 1;  @(negedge clk); tx_en_i = 0;  endtask
  task automatic pulse_dis(); tx_dis_i = 1; @(negedge clk); tx_dis_i = 0; endtask

  task automatic frame_case(string req, int len, bit pe, bit po, int sel, bit x1, int div,
                            logic [7:0] d1, logic [7:0] d2);
    int ta, tb, exp;
    wait_emt();
    char_len_i = 2'(len); par_en_i = pe; par_odd_i = po;
    stop_sel_i = 4'(sel); x1_mode_i = x1; tick_div = div;
    send(d1);
    wait_rdy();
    ta = cyc;
    send(d2);
    wait_rdy();
    tb = cyc;
    exp = div * ((1 + 5 + len + int'(pe)) * (x1 ? 1 : 16) + stop_sixteenths(len, sel, x1));
    chk(req, tb - ta, exp);
    wait_emt();
  endtask

  initial begin
    int t0;
    step(3);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 txd", txd_o, 1); chk("R1 rdy", rdy_o, 0);
    chk("R1 emt", emt_o, 0); chk("R1 rts_n", rts_no, 1);

    wr_i = 1; wdata_i = 8'h11; @(negedge clk); wr_i = 0;
    step(2);
    chk("R2 write ignored rdy", rdy_o, 0); chk("R2 write ignored emt", emt_o, 0);
    pulse_en();
    chk("R2 underrun rdy", rdy_o, 1); chk("R2 underrun emt", emt_o, 1);

    send(8'h81);
    chk("R9 rdy after write", rdy_o, 0);
    @(negedge clk);
    chk("R9 rdy after move", rdy_o, 1); chk("R9 emt busy", emt_o, 0);
    send(8'h42);
    wr_i = 1; wdata_i = 8'hFF; @(negedge clk); wr_i = 0;   // ignored, model checks line
    chk("R9 full rdy", rdy_o, 0);
    wait_emt();

    frame_case("R3 8N", 3, 0, 0, 7, 0, 1, 8'hA5, 8'h3C);
    frame_case("R3 7E", 2, 1, 0, 0, 0, 1, 8'h5A, 8'h7F);
    frame_case("R4 6O max", 1, 1, 1, 15, 0, 2, 8'h2B, 8'h15);
    frame_case("R4 8E n8", 3, 1, 0, 8, 0, 1, 8'hF0, 8'h0F);
    frame_case("R5 n0", 0, 0, 0, 0, 0, 1, 8'h15, 8'h0A);
    frame_case("R5 n5", 0, 0, 0, 5, 0, 1, 8'h1F, 8'h00);
    frame_case("R5 odd n9", 0, 1, 1, 9, 0, 1, 8'h13, 8'h06);
    frame_case("R6 1x one stop", 3, 0, 0, 3, 1, 1, 8'hC3, 8'h99);
    frame_case("R6 1x two stop", 3, 1, 0, 8, 1, 1, 8'h66, 8'h01);
    frame_case("R6 1x div3", 0, 0, 0, 12, 1, 3, 8'h1E, 8'h11);
    x1_mode_i = 0; char_len_i = 3; par_en_i = 0; stop_sel_i = 7; tick_div = 1;

    cts_gate_i = 1; cts_ni = 1;
    send(8'h55);
    step(80);
    chk("R7 line held", txd_o, 1); chk("R7 hold full", rdy_o, 0); chk("R7 not empty", emt_o, 0);
    cts_ni = 0;
    wait_rdy();
    chk("R7 starts on cts low", rdy_o, 1);
    step(20);
    cts_ni = 1;
    wait_emt();
    chk("R8 frame finished", emt_o, 1);
    cts_gate_i = 0;
    send(8'h3A);
    step(3);
    chk("R7 ungated starts", emt_o, 0);
    wait_emt();
    cts_ni = 0;

    rts_set_i = 1; @(negedge clk); rts_set_i = 0;
    chk("R10 set", rts_no, 0);
    rts_clr_i = 1; @(negedge clk); rts_clr_i = 0;
    chk("R10 clr", rts_no, 1);
    rts_set_i = 1; rts_clr_i = 1; @(negedge clk); rts_set_i = 0; rts_clr_i = 0;
    chk("R10 clr wins", rts_no, 1);

    rts_set_i = 1; @(negedge clk); rts_set_i = 0;
    rts_auto_i = 1;
    send(8'hE1);
    send(8'h1E);
    pulse_dis();
    wait_emt();
    t0 = cyc;
    chk("R11 rts held in tail", rts_no, 0); chk("R11 rdy in tail", rdy_o, 0);
    begin
      int g = 0;
      while (!rts_no && g < 500) begin @(negedge clk); g++; end
    end
    chk("R11 release delay", cyc - t0, 16);
    chk("R11 disabled rdy", rdy_o, 0); chk("R11 disabled emt", emt_o, 0);
    rts_auto_i = 0;

    pulse_en();
    rts_set_i = 1; @(negedge clk); rts_set_i = 0;
    send(8'h77);
    pulse_dis();
    begin
      int g = 0;
      while ((rdy_o || emt_o) && g < 2000) begin @(negedge clk); g++; end
    end
    chk("R12 rts kept", rts_no, 0); chk("R12 line mark", txd_o, 1);
    pulse_en();
    chk("R12 re-enabled", rdy_o, 1);
    pulse_dis();
    step(3);
    chk("R12 idle disable", rdy_o, 0);

    pulse_en();
    send(8'h5C);
    pulse_dis();
    step(5);
    pulse_en();
    wait_emt();
    step(30);
    chk("R13 still enabled", rdy_o, 1);

    step(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule